// File: doc/BRIEF.md
# Configuration Port with Key Unlock and Banked Device Registers

This block is the configuration front end of a legacy I/O controller. A host reaches it through two adjacent byte addresses on a simple byte-wide I/O bus that has an address, a read strobe, a write strobe and data. The lower address is the index port and the one above it is the data port. The pair sits at one of two selectable bases. Configuration access starts closed. The host opens it by writing a fixed key byte twice in a row to the index port, and closes it again with a separate exit byte.

While access is open, the host writes a register number to the index port. It then reads or writes that register through the data port. Register numbers below 0x30 are global: a logical-device selector, a read-only 16-bit identity word, and a small file of general settings bytes. Numbers from 0x30 upward fall into a bank that belongs to the logical device currently selected. Each device has its own copy of these registers. All global settings bytes and all banked bytes are driven out in parallel, so that the per-device logic can use them.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset, access is closed, the index register is 0x00, the device selector is 0x00, and every global settings byte and banked byte is 0x00.
- R2: The index port is at the base and the data port is at the base plus one. The base is 0x2E when `base_sel` is 0 and 0x4E when it is 1. Any access to another address has no effect.
- R3: Access opens on the clock edge of the second of two consecutive index-port writes of 0x87 made while access is closed.
- R4: While access is closed, any other index-port write and any data-port write breaks the key sequence. A single 0x87 followed by any other write leaves access closed, and two consecutive 0x87 writes are needed again.
- R5: While access is closed, reads of either port return 0xFF, writes do not change the index register, and writes change no register.
- R6: While access is open, an index-port write of 0xAA closes access. Register contents are kept, and reopening needs the full two-key sequence.
- R7: While access is open, any index-port write other than 0xAA loads the index register, and a read of the index port returns it.
- R8: Index 0x07 is the device selector. It can be read and written through the data port, and its value appears on `ldn_sel`.
- R9: Index 0x20 reads the high byte and index 0x21 reads the low byte of the identity word CHIP_ID (default 0xA235, whose upper 12 bits are 0xA23). Writes to these two indices are discarded.
- R10: Indices 0x22 to 0x2F are read/write settings bytes. Index 0x22+k appears on `glob_regs[8k+7:8k]`. Any other index below 0x30 reads 0xFF and discards writes.
- R11: Indices 0x30 to 0x3F address the bank of the device on `ldn_sel`. Offset o of device d appears on `dev_regs[8(16d+o)+7:8(16d+o)]`. A selector of 16 or more, or an index of 0x40 or above, reads 0xFF and discards writes.
- R12: Read data is combinational. `io_rdata` carries the addressed value in the same cycle as `io_rd`, and carries 0xFF when no port read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_sel | input | 1 | Base select: 0 gives 0x2E, 1 gives 0x4E |
| io_addr | input | 16 | I/O bus address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data |
| cfg_open | output | 1 | Configuration access is open |
| ldn_sel | output | 8 | Current logical device selector |
| glob_regs | output | 112 | Global settings bytes for indices 0x22..0x2F |
| dev_regs | output | 2048 | Banked bytes of all devices, 16 per device |

## Verification
Errors in the key-sequence state show at the ports as soon as they occur. If the sequence counter is wrong, `cfg_open` rises one write too early, or access stays shut after a valid pair of keys. The bench probes this with broken sequences, with keys split by data-port writes, and with keys sent to the wrong base. Corruption of the index register or the bank address shows on the next data-port read, and through the parallel `dev_regs` and `glob_regs` outputs in the cycle after the write. The bench therefore reads back each written byte, checks neighbouring devices and out-of-range selectors, and confirms that contents survive an exit and re-entry.

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_LO = 'h2E,
  parameter logic [ADDR_W-1:0] BASE_HI = 'h4E,
  parameter logic [15:0] CHIP_ID = 16'hA235,
  parameter int NUM_DEV = 16,
  parameter int BANK_REGS = 16,
  parameter int GLOB_REGS = 14
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              base_sel,
  input  logic [ADDR_W-1:0]                 io_addr,
  input  logic                              io_rd,
  input  logic                              io_wr,
  input  logic [7:0]                        io_wdata,
  output logic [7:0]                        io_rdata,
  output logic                              cfg_open,
  output logic [7:0]                        ldn_sel,
  output logic [GLOB_REGS*8-1:0]            glob_regs,
  output logic [NUM_DEV*BANK_REGS*8-1:0]    dev_regs
);
  localparam int DEV_W = $clog2(NUM_DEV);
  localparam int OFF_W = $clog2(BANK_REGS);
  localparam int CELLS = NUM_DEV * BANK_REGS;
  localparam logic [7:0] KEY_IN   = 8'h87;
  localparam logic [7:0] KEY_OUT  = 8'hAA;
  localparam logic [7:0] IX_LDN   = 8'h07;
  localparam logic [7:0] IX_IDH   = 8'h20;
  localparam logic [7:0] IX_IDL   = 8'h21;
  localparam logic [7:0] GLOB_LO  = 8'h22;
  localparam logic [7:0] GLOB_END = 8'(34 + GLOB_REGS);
  localparam logic [7:0] BANK_LO  = 8'h30;
  localparam logic [7:0] BANK_END = 8'(48 + BANK_REGS);
  localparam logic [7:0] DEV_LIM  = 8'(NUM_DEV);

  logic [ADDR_W-1:0] base;
  logic sel_idx, sel_dat, wr_idx, wr_dat;
  logic key_seen;
  logic [7:0] idx;
  logic [7:0] glob [GLOB_REGS];
  logic [7:0] bank [CELLS];
  logic in_glob, in_bank, dev_ok;
  logic [DEV_W+OFF_W-1:0] bank_addr;
  logic [7:0] rd_val;

  assign base      = base_sel ? BASE_HI : BASE_LO;
  assign sel_idx   = io_addr == base;
  assign sel_dat   = io_addr == base + ADDR_W'(1);
  assign wr_idx    = io_wr & sel_idx;
  assign wr_dat    = io_wr & sel_dat;
  assign in_glob   = idx >= GLOB_LO && idx < GLOB_END;
  assign in_bank   = idx >= BANK_LO && idx < BANK_END;
  assign dev_ok    = ldn_sel < DEV_LIM;
  assign bank_addr = {ldn_sel[DEV_W-1:0], idx[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_open <= 1'b0;
      key_seen <= 1'b0;
      idx      <= '0;
      ldn_sel  <= '0;
      for (int k = 0; k < GLOB_REGS; k++) glob[k] <= '0;
      for (int k = 0; k < CELLS; k++) bank[k] <= '0;
    end else if (!cfg_open) begin
      if (wr_idx) begin
        if (io_wdata == KEY_IN) begin
          cfg_open <= key_seen;
          key_seen <= ~key_seen;
        end else begin
          key_seen <= 1'b0;
        end
      end else if (wr_dat) begin
        key_seen <= 1'b0;
      end
    end else begin
      if (wr_idx) begin
        if (io_wdata == KEY_OUT) cfg_open <= 1'b0;
        else idx <= io_wdata;
      end
      if (wr_dat) begin
        if (idx == IX_LDN) ldn_sel <= io_wdata;
        for (int k = 0; k < GLOB_REGS; k++)
          if (idx == GLOB_LO + 8'(k)) glob[k] <= io_wdata;
        if (in_bank && dev_ok) bank[bank_addr] <= io_wdata;
      end
    end
  end

  always_comb begin
    rd_val = 8'hFF;
    if (sel_idx) begin
      rd_val = idx;
    end else begin
      case (idx)
        IX_LDN: rd_val = ldn_sel;
        IX_IDH: rd_val = CHIP_ID[15:8];
        IX_IDL: rd_val = CHIP_ID[7:0];
        default: begin
          if (in_glob) begin
            for (int k = 0; k < GLOB_REGS; k++)
              if (idx == GLOB_LO + 8'(k)) rd_val = glob[k];
          end else if (in_bank && dev_ok) begin
            rd_val = bank[bank_addr];
          end
        end
      endcase
    end
  end

  assign io_rdata = (io_rd && cfg_open && (sel_idx || sel_dat)) ? rd_val : 8'hFF;

  for (genvar g = 0; g < GLOB_REGS; g++) begin : g_glob
    assign glob_regs[g*8 +: 8] = glob[g];
  end
  for (genvar c = 0; c < CELLS; c++) begin : g_bank
    assign dev_regs[c*8 +: 8] = bank[c];
  end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int DEV_BITS = 2048,
  parameter logic [15:0] CHIP_ID = 16'hA235
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_idx,
  input logic                wr_dat,
  input logic                sel_dat,
  input logic                io_rd,
  input logic [7:0]          io_wdata,
  input logic [7:0]          io_rdata,
  input logic                cfg_open,
  input logic [7:0]          idx,
  input logic [7:0]          ldn_sel,
  input logic [DEV_BITS-1:0] dev_regs
);
  // R3
  open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(wr_idx && io_wdata == 8'h87));
  // R4
  broken_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && (wr_dat || (wr_idx && io_wdata != 8'h87))) |=> !cfg_open);
  // R5
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_rd && sel_dat) |-> io_rdata == 8'hFF);
  // R5
  locked_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(dev_regs));
  // R6
  close_needs_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_open) |-> $past(wr_idx && io_wdata == 8'hAA));
  // R8
  ldn_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_open && wr_dat && idx == 8'h07) |=> $stable(ldn_sel));
  // R9
  id_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_rd && sel_dat && idx == 8'h20) |-> io_rdata == CHIP_ID[15:8]);
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.DEV_BITS(NUM_DEV*BANK_REGS*8), .CHIP_ID(CHIP_ID)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_idx(wr_idx), .wr_dat(wr_dat), .sel_dat(sel_dat),
  .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
  .idx(idx), .ldn_sel(ldn_sel), .dev_regs(dev_regs));

// File: tb/test_sio_cfg_port.sv
module test_sio_cfg_port;
  logic clk = 0, rst_n = 0, base_sel = 0, io_rd = 0, io_wr = 0;
  logic [15:0] io_addr = 16'h0;
  logic [7:0] io_wdata = 8'h0;
  logic [7:0] io_rdata, ldn_sel;
  logic cfg_open;
  logic [111:0] glob_regs;
  logic [2047:0] dev_regs;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sio_cfg_port i_sio_cfg_port (.clk(clk), .rst_n(rst_n), .base_sel(base_sel),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .cfg_open(cfg_open), .ldn_sel(ldn_sel),
    .glob_regs(glob_regs), .dev_regs(dev_regs));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0; io_addr = 16'h0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1;
    #2 d = io_rdata;
    @(negedge clk); io_rd = 0; io_addr = 16'h0;
  endtask

  task automatic reg_wr(input logic [15:0] b, input logic [7:0] ix, input logic [7:0] d);
    wr(b, ix); wr(b + 16'd1, d);
  endtask

  task automatic reg_rd(input logic [15:0] b, input logic [7:0] ix, output logic [7:0] d);
    wr(b, ix); rd(b + 16'd1, d);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check(cfg_open == 0, "R1 closed", cfg_open, 0);
    check(ldn_sel == 0, "R1 ldn", ldn_sel, 0);
    check(glob_regs == '0 && dev_regs == '0, "R1 regs zero", 0, 0);
    rd(16'h2F, d); check(d == 8'hFF, "R5 locked data read", d, 8'hFF);
    rd(16'h2E, d); check(d == 8'hFF, "R5 locked index read", d, 8'hFF);
  endtask

  task automatic t_locked_ignore;
    wr(16'h2E, 8'h22); wr(16'h2F, 8'h5A);
    check(glob_regs == '0, "R5 locked write dropped", glob_regs[7:0], 0);
  endtask

  task automatic t_broken;
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h55); wr(16'h2E, 8'h87);
    check(cfg_open == 0, "R4 broken by index", cfg_open, 0);
    wr(16'h2F, 8'h00); wr(16'h2E, 8'h87);
    check(cfg_open == 0, "R4 broken by data write", cfg_open, 0);
  endtask

  task automatic t_unlock;
    logic [7:0] d;
    wr(16'h2E, 8'h87);
    check(cfg_open == 1, "R3 open after pair", cfg_open, 1);
    rd(16'h2E, d); check(d == 8'h00, "R1 index reset", d, 0);
    reg_rd(16'h2E, 8'h22, d); check(d == 8'h00, "R5 prior locked write", d, 0);
  endtask

  task automatic t_index;
    logic [7:0] d;
    wr(16'h2E, 8'h35); rd(16'h2E, d);
    check(d == 8'h35, "R7 index readback", d, 8'h35);
    @(negedge clk); #2 check(io_rdata == 8'hFF, "R12 idle rdata", io_rdata, 8'hFF);
  endtask

  task automatic t_chipid;
    logic [7:0] d;
    reg_rd(16'h2E, 8'h20, d); check(d == 8'hA2, "R9 id high", d, 8'hA2);
    reg_rd(16'h2E, 8'h21, d); check(d == 8'h35, "R9 id low", d, 8'h35);
    reg_wr(16'h2E, 8'h20, 8'h00); reg_rd(16'h2E, 8'h20, d);
    check(d == 8'hA2, "R9 id read-only", d, 8'hA2);
  endtask

  task automatic t_glob;
    logic [7:0] d;
    reg_wr(16'h2E, 8'h2F, 8'h77); reg_rd(16'h2E, 8'h2F, d);
    check(d == 8'h77, "R10 readback", d, 8'h77);
    check(glob_regs[13*8 +: 8] == 8'h77, "R10 exposed", glob_regs[13*8 +: 8], 8'h77);
    reg_wr(16'h2E, 8'h10, 8'h12); reg_rd(16'h2E, 8'h10, d);
    check(d == 8'hFF, "R10 unmapped global", d, 8'hFF);
  endtask

  task automatic t_bank;
    logic [7:0] d;
    reg_wr(16'h2E, 8'h07, 8'h03); reg_wr(16'h2E, 8'h35, 8'hC3);
    check(ldn_sel == 8'h03, "R8 ldn out", ldn_sel, 3);
    check(dev_regs[(3*16+5)*8 +: 8] == 8'hC3, "R11 exposed", dev_regs[(3*16+5)*8 +: 8], 8'hC3);
    reg_rd(16'h2E, 8'h35, d); check(d == 8'hC3, "R11 readback", d, 8'hC3);
    reg_wr(16'h2E, 8'h07, 8'h04); reg_rd(16'h2E, 8'h35, d);
    check(d == 8'h00, "R11 other bank", d, 0);
    reg_rd(16'h2E, 8'h07, d); check(d == 8'h04, "R8 ldn read", d, 4);
    reg_wr(16'h2E, 8'h3F, 8'h9E);
    check(dev_regs[(4*16+15)*8 +: 8] == 8'h9E, "R11 last offset", dev_regs[(4*16+15)*8 +: 8], 8'h9E);
    reg_wr(16'h2E, 8'h40, 8'h11); reg_rd(16'h2E, 8'h40, d);
    check(d == 8'hFF, "R11 beyond window", d, 8'hFF);
    reg_wr(16'h2E, 8'h07, 8'd20);
    reg_wr(16'h2E, 8'h30, 8'h66); reg_rd(16'h2E, 8'h30, d);
    check(d == 8'hFF, "R11 bad ldn read", d, 8'hFF);
    check(dev_regs[(4*16+15)*8 +: 8] == 8'h9E && dev_regs[(3*16+5)*8 +: 8] == 8'hC3,
          "R11 bad ldn no write", 0, 0);
    reg_wr(16'h2E, 8'h07, 8'h03);
  endtask

  task automatic t_exit;
    logic [7:0] d;
    wr(16'h2E, 8'hAA);
    check(cfg_open == 0, "R6 closed", cfg_open, 0);
    rd(16'h2F, d); check(d == 8'hFF, "R6 data after exit", d, 8'hFF);
    wr(16'h2E, 8'h87);
    check(cfg_open == 0, "R6 single key", cfg_open, 0);
    wr(16'h2E, 8'h87);
    check(cfg_open == 1, "R6 reopen", cfg_open, 1);
    reg_rd(16'h2E, 8'h35, d); check(d == 8'hC3, "R6 contents kept", d, 8'hC3);
    wr(16'h2E, 8'hAA);
  endtask

  task automatic t_base;
    logic [7:0] d;
    base_sel = 1;
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h87);
    check(cfg_open == 0, "R2 old base ignored", cfg_open, 0);
    wr(16'h4E, 8'h87); wr(16'h4E, 8'h87);
    check(cfg_open == 1, "R2 high base opens", cfg_open, 1);
    reg_rd(16'h4E, 8'h21, d); check(d == 8'h35, "R2 high base data", d, 8'h35);
    wr(16'h2E, 8'hAA);
    check(cfg_open == 1, "R2 stray exit ignored", cfg_open, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_locked_ignore();
    t_broken();
    t_unlock();
    t_index();
    t_chipid();
    t_glob();
    t_bank();
    t_exit();
    t_base();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule